// File: doc/BRIEF.md
# Modem Handshake Control and Status Tracker

This block is the handshake corner of an asynchronous serial controller. Software writes a small control register that drives four active-low modem outputs: terminal ready, request to send and two general-purpose outputs. A fifth bit of that register selects a loopback mode. The block also presents a status byte. Its upper half is the present level of the four incoming handshake lines: clear to send, set ready, ring and carrier. Its lower half holds one sticky change flag for each of these lines.

The four incoming lines arrive already synchronised and active high. Each change flag is set on the clock edge after its line changes level. The ring flag is the exception: it is set only when ring goes from 1 to 0. A status read strobe clears all the flags. The OR of the flags drives a single interrupt request. In loopback mode, the outputs are forced inactive and the status half takes its levels from the control bits, so software can exercise the handshake path without an external loop.

Top module: `modem_handshake_tracker`

## Requirements
- R1: A pulse on `ctrlWrEn` loads `ctrlWrData[4:0]` on that clock edge. With bit 4 clear, the outputs then show the inverse of the bits: `dtrN`=~bit0, `rtsN`=~bit1, `out1N`=~bit2, `out2N`=~bit3.
- R2: Outside loopback, `statusByte[4]`, `[5]`, `[6]` and `[7]` equal `ctsIn`, `dsrIn`, `riIn` and `dcdIn` in the same cycle.
- R3: When the clear-to-send, set-ready or carrier level changes in either direction, status bit 0, 1 or 3 is set at the next clock edge. That bit then stays set until it is cleared.
- R4: Status bit 2 is set at the next edge only when the ring level falls from 1 to 0. A rising ring level leaves bit 2 unchanged.
- R5: A pulse on `statRdEn` clears status bits 3:0 at that edge. A change detected at the same edge still sets its flag.
- R6: While control bit 4 (loopback) is set, all four modem outputs are high (inactive), whatever the other control bits hold.
- R7: In loopback, the status levels come from the control bits: clear-to-send from bit 1, set-ready from bit 0, ring from bit 2 and carrier from bit 3. These levels feed change detection. Changes on the external input lines have no effect.
- R8: `msIrq` is high exactly when any of status bits 3:0 is set.
- R9: Reset clears the control register and the change flags. It also sets the reference level of every line to 0, and it drives all modem outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control write data; bits 4:0 are used |
| statRdEn | input | 1 | Status read strobe; clears the change flags |
| ctsIn | input | 1 | Synchronised clear-to-send level |
| dsrIn | input | 1 | Synchronised data-set-ready level |
| riIn | input | 1 | Synchronised ring level |
| dcdIn | input | 1 | Synchronised carrier level |
| dtrN | output | 1 | Terminal ready, active low |
| rtsN | output | 1 | Request to send, active low |
| out1N | output | 1 | General output 1, active low |
| out2N | output | 1 | General output 2, active low |
| statusByte | output | 8 | {carrier, ring, set-ready, clear-to-send, carrier chg, ring trail, set-ready chg, clear-to-send chg} |
| msIrq | output | 1 | Modem status interrupt request |

## Verification
The lines are first toggled one at a time in both directions. This separates the any-change flags from the falling-only ring flag, and it shows that each flag belongs to its own line. Status reads are issued both on quiet cycles and in the same cycle as a line change, which tells a plain clear apart from a set that wins over a clear. Loopback is tested by driving the outputs through control writes while the external lines toggle, which shows whether the level source was switched and the pins were forced inactive. A long random walk of line levels, writes and reads, with a mid-run reset, covers the combinations the directed cases miss.

// File: rtl/mht_pkg.sv
`timescale 1ns/1ps
package mht_pkg;
  localparam int LINE_COUNT = 4;
  localparam int CTRL_WIDTH = LINE_COUNT + 1;

  typedef struct packed {
    logic clearFlags;
    logic loopSel;
  } mhtStrobe_t;
endpackage

// File: rtl/mht_ctrl.sv
`timescale 1ns/1ps
module mht_ctrl
  import mht_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  rdEn,
  output logic [LINE_COUNT-1:0] pinsN,
  output logic [LINE_COUNT-1:0] loopLevels,
  output mhtStrobe_t            strobe
);
  localparam int LOOP_BIT = CTRL_WIDTH - 1;

  logic [CTRL_WIDTH-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlReg <= '0;
    else if (wrEn) ctrlReg <= wrData[CTRL_WIDTH-1:0];
  end

  always_comb begin
    strobe.loopSel    = ctrlReg[LOOP_BIT];
    strobe.clearFlags = rdEn;
    // pins: {out2, out1, rts, dtr}, active low, parked high in loopback
    pinsN = ctrlReg[LOOP_BIT] ? '1 : ~ctrlReg[LINE_COUNT-1:0];
    // loop wiring, order {carrier, ring, setReady, clearToSend}
    loopLevels = {ctrlReg[3], ctrlReg[2], ctrlReg[0], ctrlReg[1]};
  end
endmodule

// File: rtl/mht_status.sv
`timescale 1ns/1ps
module mht_status
  import mht_pkg::*;
#(
  parameter logic [LINE_COUNT-1:0] TRAIL_MASK = 4'b0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mhtStrobe_t            strobe,
  input  logic [LINE_COUNT-1:0] lineIn,
  input  logic [LINE_COUNT-1:0] loopLevels,
  output logic [LINE_COUNT-1:0] levels,
  output logic [LINE_COUNT-1:0] flags,
  output logic                  irq
);
  logic [LINE_COUNT-1:0] prevLevels;
  logic [LINE_COUNT-1:0] hit;

  assign levels = strobe.loopSel ? loopLevels : lineIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevels <= '0;
    else       prevLevels <= levels;
  end

  for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
    if (TRAIL_MASK[i]) begin : g_trail
      assign hit[i] = prevLevels[i] & ~levels[i];
    end else begin : g_any
      assign hit[i] = prevLevels[i] ^ levels[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= (flags[i] & ~strobe.clearFlags) | hit[i];
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/modem_handshake_tracker.sv
`timescale 1ns/1ps
module modem_handshake_tracker
  import mht_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  logic       statRdEn,
  input  logic       ctsIn,
  input  logic       dsrIn,
  input  logic       riIn,
  input  logic       dcdIn,
  output logic       dtrN,
  output logic       rtsN,
  output logic       out1N,
  output logic       out2N,
  output logic [7:0] statusByte,
  output logic       msIrq
);
  mhtStrobe_t            strobe;
  logic [LINE_COUNT-1:0] pinsN;
  logic [LINE_COUNT-1:0] loopLevels;
  logic [LINE_COUNT-1:0] levels;
  logic [LINE_COUNT-1:0] flags;

  mht_ctrl #(.DATA_W(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(ctrlWrEn), .wrData(ctrlWrData),
    .rdEn(statRdEn), .pinsN(pinsN), .loopLevels(loopLevels), .strobe(strobe)
  );

  mht_status #(.TRAIL_MASK(4'b0100)) status_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lineIn({dcdIn, riIn, dsrIn, ctsIn}), .loopLevels(loopLevels),
    .levels(levels), .flags(flags), .irq(msIrq)
  );

  assign {out2N, out1N, rtsN, dtrN} = pinsN;
  assign statusByte = {levels, flags};
endmodule

// File: rtl/modem_handshake_tracker_chk.sv
`timescale 1ns/1ps
module modem_handshake_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWrEn,
  input logic [7:0] ctrlWrData,
  input logic       statRdEn,
  input logic       dtrN,
  input logic       rtsN,
  input logic       out1N,
  input logic       out2N,
  input logic [7:0] statusByte,
  input logic       msIrq
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  dtr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && !ctrlWrData[4] |=> dtrN == !$past(ctrlWrData[0]));
  // R3
  cts_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && (statusByte[4] != $past(statusByte[4])) |=> statusByte[0]);
  // R3
  dcd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && (statusByte[7] != $past(statusByte[7])) |=> statusByte[3]);
  // R4
  ri_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $fell(statusByte[6]) |=> statusByte[2]);
  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && statRdEn && $stable(statusByte[7:4]) |=> statusByte[3:0] == 4'h0);
  // R6
  loop_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn && ctrlWrData[4] |=> {dtrN, rtsN, out1N, out2N} == 4'hF);
  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    msIrq == (statusByte[3:0] != 4'h0));
endmodule

bind modem_handshake_tracker modem_handshake_tracker_chk chk_i (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .statRdEn(statRdEn), .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N),
  .statusByte(statusByte), .msIrq(msIrq)
);

// File: tb/modem_handshake_tracker_tb_top.sv
`timescale 1ns/1ps
module modem_handshake_tracker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic statRdEn = 1'b0;
  logic ctsIn = 1'b0, dsrIn = 1'b0, riIn = 1'b0, dcdIn = 1'b0;
  logic dtrN, rtsN, out1N, out2N, msIrq;
  logic [7:0] statusByte;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  int mCtrl = 0;
  int mPrev[4] = '{0, 0, 0, 0};
  int mFlag[4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  modem_handshake_tracker dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statRdEn(statRdEn), .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn),
    .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N),
    .statusByte(statusByte), .msIrq(msIrq)
  );

  // index 0 clear-to-send, 1 set-ready, 2 ring, 3 carrier
  function automatic int modelLevel(int idx);
    if ((mCtrl >> 4) & 1) begin
      case (idx)
        0: return (mCtrl >> 1) & 1;
        1: return mCtrl & 1;
        2: return (mCtrl >> 2) & 1;
        default: return (mCtrl >> 3) & 1;
      endcase
    end
    case (idx)
      0: return int'(ctsIn);
      1: return int'(dsrIn);
      2: return int'(riIn);
      default: return int'(dcdIn);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0;
      for (int i = 0; i < 4; i++) begin mPrev[i] = 0; mFlag[i] = 0; end
    end else begin
      int lv[4];
      int hit;
      for (int i = 0; i < 4; i++) lv[i] = modelLevel(i);
      for (int i = 0; i < 4; i++) begin
        if (i == 2) hit = (mPrev[i] == 1 && lv[i] == 0) ? 1 : 0;
        else        hit = (mPrev[i] != lv[i]) ? 1 : 0;
        mFlag[i] = ((statRdEn ? 0 : mFlag[i]) != 0 || hit != 0) ? 1 : 0;
        mPrev[i] = lv[i];
      end
      if (ctrlWrEn) mCtrl = int'(ctrlWrData) & 31;
    end
  end

  task automatic checkVal(string tag, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, actual, expected);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int expPins, expLev, expFlags, inLoop;
      inLoop = (mCtrl >> 4) & 1;
      expPins = inLoop ? 15 : (~mCtrl) & 15;
      expLev = 0; expFlags = 0;
      for (int i = 0; i < 4; i++) begin
        expLev |= modelLevel(i) << i;
        expFlags |= mFlag[i] << i;
      end
      checkVal(inLoop ? "R6 pins" : "R1/R9 pins",
               int'({out2N, out1N, rtsN, dtrN}), expPins);
      checkVal(inLoop ? "R7 levels" : "R2 levels", int'(statusByte[7:4]), expLev);
      checkVal("R3/R4/R5 flags", int'(statusByte[3:0]), expFlags);
      checkVal("R8 irq", int'(msIrq), expFlags != 0 ? 1 : 0);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLines(logic c, logic d, logic r, logic k);
    @(negedge clk);
    ctsIn = c; dsrIn = d; riIn = r; dcdIn = k;
  endtask

  task automatic writeCtrl(logic [7:0] v);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic readStat();
    @(negedge clk);
    statRdEn = 1'b1;
    @(negedge clk);
    statRdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(2);                                 // R9 reset state
    writeCtrl(8'h05); idle(2);               // R1
    writeCtrl(8'hEA); idle(2);               // R1 upper bits dropped
    setLines(1, 0, 0, 0); idle(2);           // R3 cts rise
    setLines(1, 1, 0, 0); idle(2);           // R3 dsr rise
    readStat(); idle(2);                     // R5
    setLines(1, 1, 1, 0); idle(2);           // R4 ring rise: no flag
    setLines(1, 1, 0, 0); idle(2);           // R4 ring fall: flag
    readStat();
    setLines(1, 1, 0, 1); idle(1);           // R3 carrier
    // R5 change in same cycle as read
    @(negedge clk); statRdEn = 1'b1; ctsIn = 1'b0;
    @(negedge clk); statRdEn = 1'b0;
    idle(2); readStat(); idle(2);
    writeCtrl(8'h1F); idle(2);               // R6/R7 loopback
    setLines(0, 0, 1, 0); idle(2);           // R7 externals ignored
    setLines(0, 0, 0, 0); idle(1);
    readStat();
    writeCtrl(8'h1B); idle(2);               // R7 ring from bit 2 falls
    writeCtrl(8'h10); idle(2);
    writeCtrl(8'h00); idle(2);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      ctsIn = 1'($urandom_range(0, 1)); dsrIn = 1'($urandom_range(0, 1));
      riIn  = 1'($urandom_range(0, 1)); dcdIn = 1'($urandom_range(0, 1));
      statRdEn = ($urandom_range(0, 3) == 0);
      ctrlWrEn = ($urandom_range(0, 7) == 0);
      ctrlWrData = 8'($urandom_range(0, 255));
      if (k == 1500) begin
        rstN = 1'b0;                         // R9 mid-run reset
        @(negedge clk); rstN = 1'b1;
      end
    end
    @(negedge clk);
    ctrlWrEn = 1'b0; statRdEn = 1'b0;
    idle(3);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule